// File: doc/BRIEF.md
# Parallel Host Bus Slave for a Display Controller

This block is the device side of an asynchronous parallel host bus with separate read and write strobes. A host selects the device with two select lines, one active low and one active high. It writes bytes to either a command port or the display memory write port, and it reads back either a status byte or display memory data. All host pins are asynchronous to the system clock. Each pin passes through a two-flop synchroniser, and the strobe edges are found in the system clock domain.

Writes take effect on the rising edge of the write strobe. The byte and the data/command select are held in a capture register while the synchronised strobe is low. The block then emits a one-cycle pulse on either the command port or the display write port.

Status reads return the status input at once. Display reads are served from a one-byte prefetch latch. Each display read returns what the latch holds and then requests the next byte from memory over a request/acknowledge pair. The memory side advances its own read address. Because of this, the first display read after reset, or after the command decoder reports a new address, returns stale latch contents and serves as a dummy read. When a new address is reported, any outstanding fetch is cancelled and its data is discarded.

Top module: `host_par_port`

## Requirements
- R1: After reset, `cmd_valid`, `pix_wr_valid`, `pix_rd_req` and `bus_d_oe` are 0, and the prefetch latch holds 8'h00.
- R2: A write strobe rising edge with the bus selected and `bus_dc`=0 gives exactly one single-cycle `cmd_valid` pulse carrying the written byte on `cmd_byte`. `pix_wr_valid` stays low.
- R3: A write strobe rising edge with the bus selected and `bus_dc`=1 gives exactly one single-cycle `pix_wr_valid` pulse carrying the written byte on `pix_wr_byte`. `cmd_valid` stays low.
- R4: The bus is selected only when `bus_sel_n`=0 and `bus_sel`=1. Strobes seen while it is unselected cause no write pulse, no fetch request and no output enable.
- R5: `bus_d_oe` equals the condition (selected, read strobe low, write strobe high) on the pins, delayed by the synchroniser depth plus one clock.
- R6: A read with `bus_dc`=0 drives the value of `status_i` on `bus_d_o` and raises no fetch request.
- R7: A read with `bus_dc`=1 drives the prefetch latch value on `bus_d_o`. It then raises `pix_rd_req` and holds it until `pix_rd_ack`; the acknowledged byte becomes the new latch value.
- R8: The first display read after reset returns 8'h00, which serves as the dummy read.
- R9: A pulse on `addr_load` drops `pix_rd_req` in the next cycle. An acknowledge arriving in the same cycle as `addr_load` leaves the latch unchanged, so the next display read returns the earlier latch value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel_n | input | 1 | Active-low device select from the host |
| bus_sel | input | 1 | Active-high device select from the host |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, acts on its rising edge |
| bus_dc | input | 1 | 1 = display data, 0 = command (write) or status (read) |
| bus_d_i | input | 8 | Data bus, inbound half |
| bus_d_o | output | 8 | Data bus, outbound half |
| bus_d_oe | output | 1 | Drive enable for the outbound half |
| status_i | input | 8 | Status byte returned on status reads |
| cmd_valid | output | 1 | One-cycle command byte strobe |
| cmd_byte | output | 8 | Command byte |
| pix_wr_valid | output | 1 | One-cycle display write strobe |
| pix_wr_byte | output | 8 | Display write byte |
| pix_rd_req | output | 1 | Prefetch request to display memory |
| pix_rd_ack | input | 1 | Memory acknowledge, qualifies `pix_rd_byte` |
| pix_rd_byte | input | 8 | Byte returned by memory |
| addr_load | input | 1 | Pulse from the command decoder: a new memory address was set |

## Verification
The fetch acknowledge and the address-load pulse can fall in the same cycle. In that case the cancel must win, and the returned byte must not reach the latch. The bench provokes this by having its memory model raise `addr_load` in exactly the cycle it acknowledges a pending fetch. It judges the outcome at the pins: `pix_rd_req` must be low afterwards, and the next display read must return the byte served before the cancelled fetch. The bench also cancels a fetch that the memory model is holding back without acknowledging.

// File: rtl/host_par_pkg.sv
// Package host_par_pkg
// Shared types for the parallel host bus slave.
// Assumes an 8-bit host data bus by default.
package host_par_pkg;
    localparam int BUS_W = 8;

    // Target selected by the data/command line.
    typedef enum logic {
        TGT_CTRL = 1'b0,
        TGT_PIX  = 1'b1
    } tgt_e;

    // Write capture record: target plus byte.
    typedef struct packed {
        tgt_e             tgt;
        logic [BUS_W-1:0] byte_v;
    } wcap_t;
endpackage

// File: rtl/host_par_sync.sv
// Module host_par_sync
// Per-bit multi-flop synchroniser for asynchronous host pins.
// Assumes each bit is an independent level signal; RST_VAL gives the idle level.
module host_par_sync #(
    parameter int            N       = 4,
    parameter int            STAGES  = 2,
    parameter logic [N-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [LAST:0] chain;

        // Shift the raw pin through STAGES flops.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[b]}};
            end else if (STAGES == 1) begin
                chain[0] <= async_i[b];
            end else begin
                chain <= {chain[LAST-1 + (STAGES == 1 ? 1 : 0):0], async_i[b]};
            end
        end

        assign sync_o[b] = chain[LAST];
    end
endmodule

// File: rtl/host_par_wr.sv
// Module host_par_wr
// Write path: captures byte and target while the synchronised write strobe is low,
// and emits one pulse per rising edge of that strobe while selected.
// Assumes the host keeps data and data/command stable for two clocks after the rise.
module host_par_wr
    import host_par_pkg::*;
#(
    parameter int DW = BUS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          wr_n_s,
    input  logic          dc_i,
    input  logic [DW-1:0] data_i,
    output logic          cmd_valid,
    output logic          pix_valid,
    output logic [DW-1:0] wbyte
);
    logic          wr_prev;
    logic          wr_rise;
    tgt_e          hold_tgt;
    logic [DW-1:0] hold_byte;

    assign wr_rise = sel & wr_n_s & ~wr_prev;

    // Remember the previous synchronised strobe level.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_prev <= 1'b1;
        else        wr_prev <= wr_n_s;
    end

    // Hold the bus byte and target while the strobe is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_tgt  <= TGT_CTRL;
            hold_byte <= '0;
        end else if (!wr_n_s) begin
            hold_tgt  <= tgt_e'(dc_i);
            hold_byte <= data_i;
        end
    end

    // Issue one pulse towards the chosen target on each rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            pix_valid <= 1'b0;
            wbyte     <= '0;
        end else begin
            cmd_valid <= wr_rise & (hold_tgt == TGT_CTRL);
            pix_valid <= wr_rise & (hold_tgt == TGT_PIX);
            if (wr_rise) wbyte <= hold_byte;
        end
    end
endmodule

// File: rtl/host_par_rd.sv
// Module host_par_rd
// Read path: serves status reads directly and display reads from a prefetch latch,
// refilling the latch by request/acknowledge. An address load cancels a fetch.
// Assumes the next display read falls only after the previous fetch has finished.
module host_par_rd
    import host_par_pkg::*;
#(
    parameter int DW = BUS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          rd_n_s,
    input  logic          wr_n_s,
    input  logic          dc_i,
    input  logic [DW-1:0] status_i,
    input  logic          fetch_ack,
    input  logic [DW-1:0] fetch_byte,
    input  logic          addr_load,
    output logic          fetch_req,
    output logic [DW-1:0] rdata,
    output logic          rdata_oe
);
    logic          rd_prev;
    logic          rd_fall;
    logic          pix_rd;
    logic [DW-1:0] latch_q;

    assign rd_fall = sel & ~rd_n_s & rd_prev;
    assign pix_rd  = rd_fall & (tgt_e'(dc_i) == TGT_PIX);

    // Track the previous synchronised read strobe level.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_prev <= 1'b1;
        else        rd_prev <= rd_n_s;
    end

    // Drive enable: selected, reading, not writing.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_oe <= 1'b0;
        else        rdata_oe <= sel & ~rd_n_s & wr_n_s;
    end

    // Load the returned byte on a read strobe fall.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata <= '0;
        else if (rd_fall) rdata <= pix_rd ? latch_q : status_i;
    end

    // Fetch request: cancel on address load, raise on display read, drop on ack.
    always_ff @(posedge clk) begin
        if (!rst_n)                      fetch_req <= 1'b0;
        else if (addr_load)              fetch_req <= 1'b0;
        else if (pix_rd)                 fetch_req <= 1'b1;
        else if (fetch_ack)              fetch_req <= 1'b0;
    end

    // Prefetch latch: accept an acknowledged byte unless cancelled.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 latch_q <= '0;
        else if (fetch_req & fetch_ack & ~addr_load) latch_q <= fetch_byte;
    end
endmodule

// File: rtl/host_par_port.sv
// Module host_par_port
// Top of the parallel host bus slave: synchronises select and strobe pins,
// then hands them to the write path and the read/prefetch path.
// Assumes data and data/command pins are stable around every strobe.
module host_par_port
    import host_par_pkg::*;
#(
    parameter int DW          = BUS_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel_n,
    input  logic          bus_sel,
    input  logic          bus_rd_n,
    input  logic          bus_wr_n,
    input  logic          bus_dc,
    input  logic [DW-1:0] bus_d_i,
    output logic [DW-1:0] bus_d_o,
    output logic          bus_d_oe,
    input  logic [DW-1:0] status_i,
    output logic          cmd_valid,
    output logic [DW-1:0] cmd_byte,
    output logic          pix_wr_valid,
    output logic [DW-1:0] pix_wr_byte,
    output logic          pix_rd_req,
    input  logic          pix_rd_ack,
    input  logic [DW-1:0] pix_rd_byte,
    input  logic          addr_load
);
    localparam int           NPIN    = 4;
    localparam logic [3:0]   PIN_IDLE = 4'b1011; // sel_n, sel, rd_n, wr_n

    logic [NPIN-1:0] pins_s;
    logic            sel_s;
    logic [DW-1:0]   wbyte;

    host_par_sync #(
        .N       (NPIN),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({bus_sel_n, bus_sel, bus_rd_n, bus_wr_n}),
        .sync_o  (pins_s)
    );

    assign sel_s = ~pins_s[3] & pins_s[2];

    host_par_wr #(.DW(DW)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel_s),
        .wr_n_s    (pins_s[0]),
        .dc_i      (bus_dc),
        .data_i    (bus_d_i),
        .cmd_valid (cmd_valid),
        .pix_valid (pix_wr_valid),
        .wbyte     (wbyte)
    );

    assign cmd_byte    = wbyte;
    assign pix_wr_byte = wbyte;

    host_par_rd #(.DW(DW)) u_rd (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel_s),
        .rd_n_s     (pins_s[1]),
        .wr_n_s     (pins_s[0]),
        .dc_i       (bus_dc),
        .status_i   (status_i),
        .fetch_ack  (pix_rd_ack),
        .fetch_byte (pix_rd_byte),
        .addr_load  (addr_load),
        .fetch_req  (pix_rd_req),
        .rdata      (bus_d_o),
        .rdata_oe   (bus_d_oe)
    );
endmodule

// File: rtl/host_par_port_chk.sv
// Module host_par_port_chk
// Protocol checker bound to host_par_port. Keeps its own delay line of the
// raw pin conditions to judge the synchronised outputs.
module host_par_port_chk #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_sel_n,
    input  logic bus_sel,
    input  logic bus_rd_n,
    input  logic bus_wr_n,
    input  logic bus_d_oe,
    input  logic cmd_valid,
    input  logic pix_wr_valid,
    input  logic pix_rd_req,
    input  logic pix_rd_ack,
    input  logic addr_load
);
    logic [SYNC_STAGES:0] oe_dly;
    logic [SYNC_STAGES:0] sel_dly;

    // Delay the raw pin conditions by the synchroniser depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_dly  <= '0;
            sel_dly <= '0;
        end else begin
            oe_dly  <= {oe_dly[SYNC_STAGES-1:0],
                        ~bus_sel_n & bus_sel & ~bus_rd_n & bus_wr_n};
            sel_dly <= {sel_dly[SYNC_STAGES-1:0], ~bus_sel_n & bus_sel};
        end
    end

    p_oe_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_d_oe == oe_dly[SYNC_STAGES]);

    p_wr_needs_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid || pix_wr_valid) |-> sel_dly[SYNC_STAGES]);

    p_one_target_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && pix_wr_valid));

    p_cmd_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    p_pix_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pix_wr_valid |=> !pix_wr_valid);

    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_rd_req && !pix_rd_ack && !addr_load) |=> pix_rd_req);

    p_cancel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        addr_load |=> !pix_rd_req);
endmodule

bind host_par_port host_par_port_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel_n    (bus_sel_n),
    .bus_sel      (bus_sel),
    .bus_rd_n     (bus_rd_n),
    .bus_wr_n     (bus_wr_n),
    .bus_d_oe     (bus_d_oe),
    .cmd_valid    (cmd_valid),
    .pix_wr_valid (pix_wr_valid),
    .pix_rd_req   (pix_rd_req),
    .pix_rd_ack   (pix_rd_ack),
    .addr_load    (addr_load)
);

// File: tb/tb_host_par_port.sv
module tb_host_par_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel_n = 1'b1, bus_sel = 1'b0, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
    logic       bus_dc = 1'b0;
    logic [7:0] bus_d_i = '0, status_i = '0, pix_rd_byte = '0;
    logic       pix_rd_ack = 1'b0, addr_load = 1'b0;
    logic [7:0] bus_d_o, cmd_byte, pix_wr_byte;
    logic       bus_d_oe, cmd_valid, pix_wr_valid, pix_rd_req;

    int checks = 0, errors = 0;
    int n_cmd = 0, n_pix = 0, n_oe = 0, n_ack = 0;
    logic [7:0] last_cmd = '0, last_pix = '0;
    logic [7:0] latch_m = '0, ram_addr = '0, set_val = '0;
    bit hold_ram = 0, set_now = 0, set_align = 0, saw_req = 0;
    int wait_cnt = 0, target = 1;
    bit done = 0;

    always #2 clk = ~clk;

    host_par_port dut (.*);

    function automatic logic [7:0] ram_f(input logic [7:0] a);
        return (a * 8'd29) ^ 8'h5A;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Monitor write pulses and drive enable cycles.
    initial forever begin
        @(negedge clk);
        if (cmd_valid)    begin n_cmd++; last_cmd = cmd_byte; end
        if (pix_wr_valid) begin n_pix++; last_pix = pix_wr_byte; end
        if (bus_d_oe)     n_oe++;
    end

    // Display memory model with request/acknowledge and address loads.
    initial forever begin
        @(negedge clk);
        pix_rd_ack = 1'b0;
        addr_load  = 1'b0;
        if (pix_rd_req && !hold_ram) begin
            saw_req = 1;
            if (wait_cnt < target) wait_cnt++;
            else begin
                pix_rd_ack  = 1'b1;
                pix_rd_byte = ram_f(ram_addr);
                ram_addr++;
                n_ack++;
                if (set_align) begin
                    addr_load = 1'b1; ram_addr = set_val; set_align = 0;
                end else latch_m = pix_rd_byte;
                wait_cnt = 0;
                target   = 1 + int'($urandom % 3);
            end
        end else if (pix_rd_req) saw_req = 1;
        if (set_now) begin
            addr_load = 1'b1; ram_addr = set_val; set_now = 0; wait_cnt = 0;
        end
    end

    task automatic bus_write(input bit dc, input logic [7:0] b, input bit sel_ok);
        int c0 = n_cmd, p0 = n_pix;
        bus_sel_n = sel_ok ? 1'b0 : ($urandom % 2 == 0);
        bus_sel   = sel_ok ? 1'b1 : !bus_sel_n ? 1'b0 : ($urandom % 2 == 1);
        bus_dc = dc; bus_d_i = b;
        cyc(2); bus_wr_n = 1'b0; cyc(4); bus_wr_n = 1'b1; cyc(4);
        bus_sel_n = 1'b1; bus_sel = 1'b0; cyc(4);
        if (!sel_ok) begin
            chk("R4 unselected write cmd", n_cmd - c0, 0);
            chk("R4 unselected write pix", n_pix - p0, 0);
        end else if (!dc) begin
            chk("R2 cmd pulse count", n_cmd - c0, 1);
            chk("R2 cmd byte", last_cmd, b);
            chk("R2 no pix pulse", n_pix - p0, 0);
        end else begin
            chk("R3 pix pulse count", n_pix - p0, 1);
            chk("R3 pix byte", last_pix, b);
            chk("R3 no cmd pulse", n_cmd - c0, 0);
        end
    endtask

    // Read; returns the byte seen on the bus while enabled.
    task automatic bus_read(input bit dc, input bit sel_ok, output logic [7:0] got);
        int o0 = n_oe;
        logic [7:0] exp_v;
        saw_req = 0;
        exp_v = dc ? latch_m : status_i;
        bus_sel_n = sel_ok ? 1'b0 : 1'b1;
        bus_sel   = 1'b1;
        bus_dc = dc;
        cyc(2); bus_rd_n = 1'b0; cyc(5);
        got = bus_d_o;
        if (sel_ok) begin
            chk("R5 oe during read", bus_d_oe, 1);
            chk(dc ? "R7 display read byte" : "R6 status byte", got, exp_v);
        end
        bus_rd_n = 1'b1; cyc(4);
        chk("R5 oe after release", bus_d_oe, 0);
        bus_sel_n = 1'b1; bus_sel = 1'b0; cyc(8);
        if (!sel_ok) begin
            chk("R4 no oe unselected", n_oe - o0, 0);
            chk("R4 no fetch unselected", saw_req, 0);
        end else if (!dc) chk("R6 no fetch on status", saw_req, 0);
        else begin
            chk("R7 fetch raised", saw_req, 1);
            chk("R7 fetch done", pix_rd_req, 0);
        end
    endtask

    logic [7:0] got, prev;

    initial begin
        cyc(4);
        rst_n = 1'b1;
        cyc(1);
        chk("R1 cmd_valid", cmd_valid, 0);
        chk("R1 pix_wr_valid", pix_wr_valid, 0);
        chk("R1 pix_rd_req", pix_rd_req, 0);
        chk("R1 bus_d_oe", bus_d_oe, 0);

        // Dummy read after reset returns the cleared latch.
        bus_read(1'b1, 1'b1, got);
        chk("R8 dummy read zero", got, 8'h00);
        bus_read(1'b1, 1'b1, got);
        chk("R7 first real byte", got, ram_f(8'h00));

        bus_write(1'b0, 8'hA5, 1'b1);
        bus_write(1'b1, 8'h3C, 1'b1);
        status_i = 8'h81;
        bus_read(1'b0, 1'b1, got);
        bus_write(1'b0, 8'h11, 1'b0);
        bus_read(1'b1, 1'b0, got);

        // Cancel of a held-back fetch: latch keeps the served byte.
        prev = latch_m;
        hold_ram = 1;
        saw_req = 0;
        bus_sel_n = 1'b0; bus_sel = 1'b1; bus_dc = 1'b1;
        cyc(2); bus_rd_n = 1'b0; cyc(5); bus_rd_n = 1'b1; cyc(3);
        bus_sel_n = 1'b1; bus_sel = 1'b0;
        chk("R7 req held while unacked", pix_rd_req, 1);
        set_val = 8'h40; set_now = 1; cyc(3);
        chk("R9 req dropped by addr_load", pix_rd_req, 0);
        hold_ram = 0; cyc(4);
        bus_read(1'b1, 1'b1, got);
        chk("R9 stale after cancel", got, prev);

        // Ack and address load in the same cycle.
        prev = latch_m;
        set_val = 8'h80; set_align = 1;
        bus_read(1'b1, 1'b1, got);
        chk("R9 same-cycle req low", pix_rd_req, 0);
        bus_read(1'b1, 1'b1, got);
        chk("R9 same-cycle latch kept", got, prev);
        bus_read(1'b1, 1'b1, got);
        chk("R9 data from new address", got, ram_f(8'h80));

        // Random mix of operations.
        for (int i = 0; i < 80; i++) begin
            int op = int'($urandom % 6);
            case (op)
                0: bus_write(1'b0, 8'($urandom), 1'b1);
                1: bus_write(1'b1, 8'($urandom), 1'b1);
                2: begin status_i = 8'($urandom); bus_read(1'b0, 1'b1, got); end
                3: bus_read(1'b1, 1'b1, got);
                4: if ($urandom % 2) bus_write(1'($urandom), 8'($urandom), 1'b0);
                   else bus_read(1'($urandom), 1'b0, got);
                default: begin set_val = 8'($urandom); set_now = 1; cyc(3); end
            endcase
        end
        done = 1;
    end

    initial begin
        $urandom(32'd1234);
        fork
            wait (done);
            begin repeat (150000) @(posedge clk); checks++; errors++;
                  $display("FAIL watchdog actual=hung expected=done"); end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule